// File: doc/BRIEF.md
# Shift and Single-Bit Operation Unit

This execution unit serves a 32-bit core. It performs an arithmetic shift left or right on a long operand. It can also test, flip, clear or set one addressed bit of an operand. An operation is issued by raising `issue` for one clock with the opcode and operands applied. The result, a write-enable pulse and the updated condition-code register appear on the outputs after the next rising edge.

The shift count comes from a count register or from a 3-bit immediate. The bit number comes from a register or from an 8-bit immediate, and it is reduced according to the operand size. The unit holds the condition-code register itself. Instruction decode, address calculation and memory traffic belong to other blocks.

Opcode encoding on `opSel`: 0 shift left, 1 shift right, 2 bit test, 3 bit flip, 4 bit clear, 5 bit set, 6 and 7 reserved. Condition-code layout on `ccr`: bit 4 X (extend), bit 3 N, bit 2 Z, bit 1 V, bit 0 C.

Top module: `shbit_unit`

## Requirements
- R1: Shift left (opSel 0) by n in 1..32 gives operand<<n with zeros entering at bit 0. C and X both take the last bit that leaves bit 31, which is operand bit 32-n.
- R2: Shift right (opSel 1) by n in 1..31 copies the original bit 31 into the vacated upper bits. C and X both take operand bit n-1, the last bit that leaves bit 0.
- R3: With `useImm`=0 the shift count is `regVal[5:0]`, which gives 0..63. With `useImm`=1 it is `immVal[2:0]`, where code 0 means 8. Shifts always work on all 32 bits, whatever `sizeLong` is.
- R4: A shift count of zero returns the operand unchanged, clears C and leaves X as it was.
- R5: When the count exceeds 32, shift left gives zero with C=X=0. When the count is 32 or more, shift right gives 32 copies of the sign bit with C=X=sign.
- R6: Every shift sets N to result bit 31, sets Z to (result==0) and clears V.
- R7: Bit test (opSel 2) sets Z to the inverse of the addressed bit and keeps `wrEn` low, so `result` keeps its previous value.
- R8: Bit flip (3), bit clear (4) and bit set (5) each set Z to the inverse of the addressed bit as it was before the change. The result is the operand with only that bit inverted, forced to 0 or forced to 1 respectively.
- R9: The bit number is `immVal` when `useImm`=1 and `regVal[7:0]` otherwise. It is taken modulo 32 when `sizeLong`=1 and modulo 8 when `sizeLong`=0.
- R10: Bit operations leave X, N, V and C unchanged.
- R11: Outputs are registered. `wrEn` is high for exactly one cycle after issuing a shift, flip, clear or set. When `issue` is low, `wrEn` stays low and `ccr` holds.
- R12: Reserved opcodes 6 and 7 write nothing and leave `ccr` unchanged.
- R13: While reset is active, `result`, `wrEn` and `ccr` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| issue | input | 1 | Start an operation this cycle |
| opSel | input | 3 | Operation code |
| useImm | input | 1 | Take count or bit number from `immVal` rather than `regVal` |
| sizeLong | input | 1 | 1 = long operand, 0 = byte operand (bit operations only) |
| operand | input | 32 | Value to shift or modify |
| regVal | input | 32 | Register holding the count or bit number |
| immVal | input | 8 | Immediate count (low 3 bits) or bit number |
| result | output | 32 | Registered result |
| wrEn | output | 1 | Destination write strobe |
| ccr | output | 5 | Condition codes {X,N,Z,V,C} |

## Verification
The bench runs every register count from 0 to 63 and every immediate code on both shift directions, over operands chosen so that the sign bit and the end bits differ. These sweeps catch an off-by-one in the carry source, a count of 32 that loses its final carry, and a zero count that overwrites X. The bench also runs all 64 register and immediate bit numbers at both sizes. A design that reduces the bit number with the wrong mask, or takes Z from the modified bit, fails these. Bit tests and reserved opcodes are followed by checks on `result`, `wrEn` and all five flags, which show any write that slips through or any flag that gets disturbed.

// File: rtl/shbit_pkg.sv
package shbit_pkg;

  typedef enum logic [2:0] {
    OP_SHL  = 3'd0,
    OP_SHR  = 3'd1,
    OP_TST  = 3'd2,
    OP_FLIP = 3'd3,
    OP_CLR  = 3'd4,
    OP_SET  = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    BA_KEEP = 2'd0,
    BA_FLIP = 2'd1,
    BA_ZERO = 2'd2,
    BA_ONE  = 2'd3
  } bit_act_e;

  typedef struct packed {
    logic     doShift;
    logic     shiftRight;
    logic     doBit;
    bit_act_e bitAct;
    logic     writeBack;
  } strobe_t;

  localparam int CCR_X = 4;
  localparam int CCR_N = 3;
  localparam int CCR_Z = 2;
  localparam int CCR_V = 1;
  localparam int CCR_C = 0;

endpackage

// File: rtl/shbit_ctrl.sv
module shbit_ctrl
  import shbit_pkg::*;
(
  input  logic       issue,
  input  logic [2:0] opSel,
  output strobe_t    stb
);

  op_e opCode;
  assign opCode = op_e'(opSel);

  always_comb begin
    stb = '0;
    if (issue) begin
      unique case (opCode)
        OP_SHL:  begin stb.doShift = 1'b1; stb.writeBack = 1'b1; end
        OP_SHR:  begin stb.doShift = 1'b1; stb.shiftRight = 1'b1; stb.writeBack = 1'b1; end
        OP_TST:  begin stb.doBit = 1'b1; stb.bitAct = BA_KEEP; end
        OP_FLIP: begin stb.doBit = 1'b1; stb.bitAct = BA_FLIP; stb.writeBack = 1'b1; end
        OP_CLR:  begin stb.doBit = 1'b1; stb.bitAct = BA_ZERO; stb.writeBack = 1'b1; end
        OP_SET:  begin stb.doBit = 1'b1; stb.bitAct = BA_ONE;  stb.writeBack = 1'b1; end
        default: stb = '0;
      endcase
    end
  end

endmodule

// File: rtl/shbit_dp.sv
module shbit_dp
  import shbit_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int IMM_W  = 8,
  parameter int QCNT_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic              useImm,
  input  logic              sizeLong,
  input  logic [DATA_W-1:0] operand,
  input  logic [DATA_W-1:0] regVal,
  input  logic [IMM_W-1:0]  immVal,
  output logic [DATA_W-1:0] result,
  output logic              wrEn,
  output logic [4:0]        ccr
);

  localparam int BIT_W  = $clog2(DATA_W);
  localparam int BB_W   = $clog2(BYTE_W);
  localparam int CNT_W  = BIT_W + 1;
  localparam int QMAX   = 1 << QCNT_W;

  logic unusedRegBits;
  assign unusedRegBits = ^regVal[DATA_W-1:CNT_W];

  // shift count selection
  logic [CNT_W-1:0] shCnt;
  logic [QCNT_W-1:0] quickCnt;
  assign quickCnt = immVal[QCNT_W-1:0];
  always_comb begin
    if (useImm)
      shCnt = (quickCnt == '0) ? CNT_W'(QMAX) : CNT_W'(quickCnt);
    else
      shCnt = regVal[CNT_W-1:0];
  end

  // shifters with a guard bit catching the last bit out
  logic [DATA_W:0]        leftExt;
  logic signed [DATA_W:0] rightExt;
  assign leftExt  = {1'b0, operand} << shCnt;
  assign rightExt = $signed({operand, 1'b0}) >>> shCnt;

  logic [DATA_W-1:0] shRes;
  logic              shOut;
  assign shRes = stb.shiftRight ? rightExt[DATA_W:1] : leftExt[DATA_W-1:0];
  assign shOut = stb.shiftRight ? rightExt[0] : leftExt[DATA_W];

  // bit number selection and one-hot mask
  logic [IMM_W-1:0] bitSrc;
  logic [BIT_W-1:0] bitIdx;
  assign bitSrc = useImm ? immVal : regVal[IMM_W-1:0];
  assign bitIdx = sizeLong ? bitSrc[BIT_W-1:0] : BIT_W'(bitSrc[BB_W-1:0]);

  logic [DATA_W-1:0] bitMask;
  genvar g;
  generate
    for (g = 0; g < DATA_W; g++) begin : g_mask
      assign bitMask[g] = (bitIdx == BIT_W'(g));
    end
  endgenerate

  logic oldBit;
  assign oldBit = |(operand & bitMask);

  logic [DATA_W-1:0] bitRes;
  always_comb begin
    unique case (stb.bitAct)
      BA_FLIP: bitRes = operand ^ bitMask;
      BA_ZERO: bitRes = operand & ~bitMask;
      BA_ONE:  bitRes = operand | bitMask;
      default: bitRes = operand;
    endcase
  end

  // next condition codes
  logic [4:0] ccrNext;
  always_comb begin
    ccrNext = ccr;
    if (stb.doShift) begin
      if (shCnt != '0) ccrNext[CCR_X] = shOut;
      ccrNext[CCR_N] = shRes[DATA_W-1];
      ccrNext[CCR_Z] = (shRes == '0);
      ccrNext[CCR_V] = 1'b0;
      ccrNext[CCR_C] = shOut;
    end else if (stb.doBit) begin
      ccrNext[CCR_Z] = ~oldBit;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result <= '0;
      wrEn   <= 1'b0;
      ccr    <= '0;
    end else begin
      wrEn <= stb.writeBack;
      ccr  <= ccrNext;
      if (stb.writeBack) result <= stb.doShift ? shRes : bitRes;
    end
  end

endmodule

// File: rtl/shbit_unit.sv
module shbit_unit #(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int IMM_W  = 8,
  parameter int QCNT_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              issue,
  input  logic [2:0]        opSel,
  input  logic              useImm,
  input  logic              sizeLong,
  input  logic [DATA_W-1:0] operand,
  input  logic [DATA_W-1:0] regVal,
  input  logic [IMM_W-1:0]  immVal,
  output logic [DATA_W-1:0] result,
  output logic              wrEn,
  output logic [4:0]        ccr
);

  shbit_pkg::strobe_t stb;

  shbit_ctrl u_ctrl (
    .issue (issue),
    .opSel (opSel),
    .stb   (stb)
  );

  shbit_dp #(
    .DATA_W (DATA_W),
    .BYTE_W (BYTE_W),
    .IMM_W  (IMM_W),
    .QCNT_W (QCNT_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .useImm   (useImm),
    .sizeLong (sizeLong),
    .operand  (operand),
    .regVal   (regVal),
    .immVal   (immVal),
    .result   (result),
    .wrEn     (wrEn),
    .ccr      (ccr)
  );

endmodule

// File: rtl/shbit_unit_chk.sv
module shbit_unit_chk #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              issue,
  input logic [2:0]        opSel,
  input logic              useImm,
  input logic [DATA_W-1:0] operand,
  input logic [DATA_W-1:0] regVal,
  input logic [IMM_W-1:0]  immVal,
  input logic [DATA_W-1:0] result,
  input logic              wrEn,
  input logic [4:0]        ccr
);

  localparam int CNT_W = $clog2(DATA_W) + 1;

  logic isShift, isBitOp, isRsv, zeroCnt;
  assign isShift = issue && (opSel <= 3'd1);
  assign isBitOp = issue && (opSel >= 3'd2) && (opSel <= 3'd5);
  assign isRsv   = issue && (opSel >= 3'd6);
  assign zeroCnt = !useImm && (regVal[CNT_W-1:0] == '0);

  // R7
  a_r7_test_no_write: assert property (@(posedge clk) disable iff (!rstN)
    (issue && opSel == 3'd2) |=> !wrEn);

  // R11
  a_r11_idle_no_write: assert property (@(posedge clk) disable iff (!rstN)
    !issue |=> (!wrEn && $stable(ccr)));

  // R6
  a_r6_shift_flags: assert property (@(posedge clk) disable iff (!rstN)
    isShift |=> (!ccr[1] && ccr[2] == (result == '0) && ccr[3] == result[DATA_W-1]));

  // R4
  a_r4_zero_count: assert property (@(posedge clk) disable iff (!rstN)
    (isShift && zeroCnt) |=> (result == $past(operand) && !ccr[0] && ccr[4] == $past(ccr[4])));

  // R1 / R2: extend follows carry for a nonzero count
  a_r1_extend_tracks_carry: assert property (@(posedge clk) disable iff (!rstN)
    (isShift && !zeroCnt) |=> (ccr[4] == ccr[0]));

  // R10
  a_r10_bit_keeps_flags: assert property (@(posedge clk) disable iff (!rstN)
    isBitOp |=> (ccr[4] == $past(ccr[4]) && ccr[3] == $past(ccr[3]) &&
                 ccr[1] == $past(ccr[1]) && ccr[0] == $past(ccr[0])));

  // R12
  a_r12_reserved_inert: assert property (@(posedge clk) disable iff (!rstN)
    isRsv |=> (!wrEn && $stable(ccr) && $stable(result)));

endmodule

bind shbit_unit shbit_unit_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .issue   (issue),
  .opSel   (opSel),
  .useImm  (useImm),
  .operand (operand),
  .regVal  (regVal),
  .immVal  (immVal),
  .result  (result),
  .wrEn    (wrEn),
  .ccr     (ccr)
);

// File: tb/shbit_unit_bench.sv
`timescale 1ns/1ps
module shbit_unit_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        issue = 1'b0;
  logic [2:0]  opSel = '0;
  logic        useImm = 1'b0;
  logic        sizeLong = 1'b1;
  logic [31:0] operand = '0;
  logic [31:0] regVal = '0;
  logic [7:0]  immVal = '0;
  logic [31:0] result;
  logic        wrEn;
  logic [4:0]  ccr;

  int nRun = 0;
  int nFail = 0;
  logic [31:0] mRes = '0;
  logic [4:0]  mCcr = '0;

  always #2.5 clk = ~clk;

  shbit_unit u_shbit_unit (
    .clk(clk), .rstN(rstN), .issue(issue), .opSel(opSel), .useImm(useImm),
    .sizeLong(sizeLong), .operand(operand), .regVal(regVal), .immVal(immVal),
    .result(result), .wrEn(wrEn), .ccr(ccr)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic runOp(input logic [2:0] op, input logic [31:0] opnd,
                       input logic [31:0] rv, input logic [7:0] imm,
                       input logic useI, input logic szL);
    logic [31:0] v;
    logic        c, eWr;
    int          n, idx;
    logic [7:0]  b;
    string       tag, ftag;
    v = opnd; c = 1'b0; eWr = 1'b0;
    tag = "R12"; ftag = "R12";
    if (op <= 3'd1) begin
      n = useI ? ((imm[2:0] == 3'd0) ? 8 : int'(imm[2:0])) : int'(rv[5:0]);
      for (int i = 0; i < n; i++) begin
        if (op == 3'd0) begin c = v[31]; v = {v[30:0], 1'b0}; end
        else            begin c = v[0];  v = {v[31], v[31:1]}; end
      end
      if (n != 0) mCcr[4] = c;
      mCcr[3] = v[31]; mCcr[2] = (v == 32'd0); mCcr[1] = 1'b0; mCcr[0] = c;
      mRes = v; eWr = 1'b1; ftag = "R6";
      if (n == 0)       tag = "R4";
      else if (n >= 32) tag = "R5";
      else if (useI)    tag = "R3";
      else              tag = (op == 3'd0) ? "R1" : "R2";
    end else if (op <= 3'd5) begin
      b = useI ? imm : rv[7:0];
      idx = szL ? int'(b) % 32 : int'(b) % 8;
      mCcr[2] = ~opnd[idx];
      v = opnd;
      case (op)
        3'd3: v[idx] = ~v[idx];
        3'd4: v[idx] = 1'b0;
        3'd5: v[idx] = 1'b1;
        default: ;
      endcase
      eWr = (op != 3'd2);
      if (eWr) mRes = v;
      ftag = "R10";
      tag = !szL ? "R9" : (op == 3'd2) ? "R7" : "R8";
    end
    @(negedge clk);
    opSel = op; operand = opnd; regVal = rv; immVal = imm;
    useImm = useI; sizeLong = szL; issue = 1'b1;
    @(negedge clk);
    issue = 1'b0;
    chk(result == mRes, tag, "result", result, mRes);
    chk(ccr == mCcr, ftag, "ccr", {27'd0, ccr}, {27'd0, mCcr});
    chk(wrEn == eWr, "R11", "wrEn", {31'd0, wrEn}, {31'd0, eWr});
  endtask

  logic [31:0] pats [6] = '{32'h8000_0001, 32'h7FFF_FFFE, 32'hA5C3_0F96,
                            32'h0000_0000, 32'hFFFF_FFFF, 32'h4000_8002};

  initial begin : watchdog
    #900000;
    nFail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R13: reset state
    chk(result == 32'd0 && wrEn == 1'b0 && ccr == 5'd0, "R13", "reset",
        {result[26:0], wrEn, ccr[3:0]}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    // R11: idle cycles change nothing
    @(negedge clk);
    chk(wrEn == 1'b0 && ccr == 5'd0, "R11", "idle", {27'd0, ccr}, 32'd0);

    // shifts: register counts 0..63 and all immediate codes
    for (int p = 0; p < 6; p++)
      for (int d = 0; d < 2; d++) begin
        for (int k = 0; k < 64; k++)
          runOp(3'(d), pats[p], 32'hFFFF_FFC0 | 32'(k), 8'hF8, 1'b0, 1'b1);
        for (int k = 0; k < 8; k++)
          runOp(3'(d), pats[p], 32'h0, 8'(k) | 8'hA8, 1'b1, 1'b0);
      end

    // bit operations: every op, both sizes, both sources
    for (int p = 0; p < 6; p += 2)
      for (int op = 2; op < 6; op++)
        for (int sz = 0; sz < 2; sz++)
          for (int k = 0; k < 64; k++) begin
            runOp(3'(op), pats[p], 32'h1234_5600 | 32'(k), 8'd0, 1'b0, 1'(sz));
            runOp(3'(op), pats[p] ^ 32'h0F0F_0F0F, 32'h0, 8'(k * 3), 1'b1, 1'(sz));
          end

    // R10: flags set by a shift survive a following bit op
    runOp(3'd0, 32'hC000_0000, 32'd1, 8'd0, 1'b0, 1'b1);
    runOp(3'd5, 32'h0000_0000, 32'd3, 8'd0, 1'b0, 1'b1);

    // R12: reserved opcodes
    for (int op = 6; op < 8; op++)
      runOp(3'(op), 32'hDEAD_BEEF, 32'd5, 8'd9, 1'b0, 1'b1);

    // R11: hold after idle
    @(negedge clk);
    @(negedge clk);
    chk(wrEn == 1'b0, "R11", "idle wrEn", {31'd0, wrEn}, 32'd0);
    chk(ccr == mCcr && result == mRes, "R11", "idle hold", {27'd0, ccr}, {27'd0, mCcr});

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule